// File: doc/BRIEF.md
# Reset-Time Configuration Word Loader

After every reset this block fetches four 32-bit configuration words from a nonvolatile information area through a simple read port. The port carries an address, a request and a valid strobe. Each word carries two 16-bit entries. In each entry the low byte is the setting and the high byte should be its bitwise inverse. Every entry is screened. An entry whose high byte is the inverse of its low byte passes its low byte through. An entry with both bytes at 0xFF counts as blank and yields 0xFF. Any other entry is damaged: it yields 0xFF and sets an error flag, which stays set until the next reset.

The screened bytes are packed into two 32-bit outputs, a user-configuration register and a write-protection status register. The access-protection byte is decoded into none, low and high levels. Both registers read as all ones while the load runs. A done output rises once both registers hold their final values. Stored contents only take effect at the next reset, because the loader runs once per reset and then goes quiet.

Top module: `nvcfg_loader`

## Requirements
- R1: After reset the block reads exactly four words, at BASE_ADDR, BASE_ADDR+4, BASE_ADDR+8 and BASE_ADDR+12, in that order. `rd_req_o` stays high with a stable address until a cycle with `rd_valid_i` high accepts `rd_data_i`.
- R2: Until `load_done_o` rises, `ucfg_o` and `wprot_o` read 0xFFFFFFFF and `prot_lvl_o` reads 2'b11. This also holds while reset is asserted.
- R3: An entry whose high byte (bits 15:8 of the entry) equals the inverse of its low byte (bits 7:0) delivers its low byte unchanged and raises no error.
- R4: An entry with both bytes 0xFF is blank. It delivers 0xFF and raises no error.
- R5: Any other entry delivers 0xFF and sets `cfg_err_o`. The flag stays set until reset, and after the load `ucfg_o[0]` equals it.
- R6: Entry positions are fixed. Word 0 holds the access entry in bits 15:0 and the system-setting entry in bits 31:16. Word 1 holds user byte 0 in bits 15:0 and user byte 1 in bits 31:16. After the load, `ucfg_o[9:2]` holds the system-setting byte, `ucfg_o[17:10]` holds user byte 0, `ucfg_o[25:18]` holds user byte 1, and `ucfg_o[31:27]` is zero.
- R7: `wprot_o[7:0]` and `wprot_o[15:8]` come from the low and high entries of word 2. `wprot_o[23:16]` and `wprot_o[31:24]` come from the low and high entries of word 3. A 0 bit means erase/write protection is on.
- R8: Access byte 0xA5 gives `ucfg_o[1]`=0, `ucfg_o[26]`=0 and `prot_lvl_o`=2'b00. Access byte 0xCC gives bits 1 and 26 both at 1 and `prot_lvl_o`=2'b10. Any other value gives bit 1=1, bit 26=0 and `prot_lvl_o`=2'b01.
- R9: `load_done_o` rises one cycle after the fourth word is accepted, at the same edge that writes both registers. It then stays high. No further request is issued and the outputs hold until reset.
- R10: A new reset clears the error flag and the done output, returns the registers to all ones, and loads the current stored contents afresh.
- R11: `rd_data_i` has no effect in cycles where `rd_valid_i` is low, so read latency does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; each release starts a load |
| rd_req_o | output | 1 | Read request to the information area |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid; accepts the word this cycle |
| rd_data_i | input | 32 | Read data |
| load_done_o | output | 1 | Load complete, registers final |
| cfg_err_o | output | 1 | Sticky damaged-entry flag |
| ucfg_o | output | 32 | User-configuration register |
| wprot_o | output | 32 | Write-protection status register |
| prot_lvl_o | output | 2 | Access-protection level: 00 none, 01 low, 10 high, 11 pending |

## Verification
One sweep walks the access byte over all 256 values, each with a correct complement, and derives the other seven entries from it. This separates the two key values from every other byte and exposes any swapped or shifted field in either register. A second sweep puts each of 256 low bytes against four kinds of high byte: the true inverse, the inverse with one bit flipped, 0xFF, and a copy of the low byte. The damaged entry rotates through all eight positions. This tells a valid entry from a blank one and from a near miss, and shows that only the damaged entry is replaced. Read latency varies between loads so that data presented while valid is low would show up as a wrong field.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_LOW  = 2'b01,
      LVL_HIGH = 2'b10,
      LVL_PEND = 2'b11
   } prot_lvl_e;

   typedef enum logic [1:0] {
      ST_FETCH = 2'b00,
      ST_PACK  = 2'b01,
      ST_DONE  = 2'b10
   } seq_state_e;

   // access byte keys
   localparam logic [7:0] KEY_OPEN = 8'hA5;
   localparam logic [7:0] KEY_HIGH = 8'hCC;

   // entry slots, in fetch order (two per word)
   localparam int PR_ACC  = 0;
   localparam int PR_SYS  = 1;
   localparam int PR_USR0 = 2;
   localparam int PR_USR1 = 3;
   localparam int PR_WP0  = 4;

   // user-configuration register fields
   localparam int FLD_ERR     = 0;
   localparam int FLD_PROT_EN = 1;
   localparam int FLD_SYS     = 2;
   localparam int FLD_USR0    = 10;
   localparam int FLD_USR1    = 18;
   localparam int FLD_PROT_HI = 26;

endpackage

// File: rtl/nvcfg_pair_check.sv
module nvcfg_pair_check #(
   parameter int BYTE_W       = 8,
   parameter bit ACCEPT_BLANK = 1'b1
) (
   input  logic [2*BYTE_W-1:0] pair_i,
   output logic [BYTE_W-1:0]   value_o,
   output logic                bad_o
);

   localparam logic [BYTE_W-1:0] ONES = '1;

   logic [BYTE_W-1:0] lo;
   logic [BYTE_W-1:0] hi;
   logic              compl_ok;
   logic              blank;

   assign lo       = pair_i[BYTE_W-1:0];
   assign hi       = pair_i[2*BYTE_W-1:BYTE_W];
   assign compl_ok = (hi == ~lo);

   generate
      if (ACCEPT_BLANK) begin : g_blank_ok
         assign blank = (lo == ONES) && (hi == ONES);
      end else begin : g_strict
         assign blank = 1'b0;
      end
   endgenerate

   assign bad_o   = !(compl_ok || blank);
   assign value_o = bad_o ? ONES : lo;

endmodule

// File: rtl/nvcfg_read_seq.sv
module nvcfg_read_seq import nvcfg_pkg::*; #(
   parameter int ADDR_W    = 12,
   parameter int BASE_ADDR = 'h800,
   parameter int STRIDE    = 4,
   parameter int NUM_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   output logic              take_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              pack_o,
   output logic              done_o
);

   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_WORDS - 1);
   localparam logic [ADDR_W-1:0] START    = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STRIDE);

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q;

   assign rd_req_o  = (state_q == ST_FETCH);
   assign rd_addr_o = addr_q;
   assign take_o    = rd_req_o && rd_valid_i;
   assign idx_o     = idx_q;
   assign pack_o    = (state_q == ST_PACK);
   assign done_o    = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         idx_q   <= '0;
         addr_q  <= START;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               if (take_o) begin
                  addr_q <= addr_q + STEP;
                  if (idx_q == LAST_IDX) begin
                     state_q <= ST_PACK;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_PACK:  state_q <= ST_DONE;
            default:  state_q <= ST_DONE;
         endcase
      end
   end

   // R1: an open request holds its address until accepted
   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R1: every accepted word advances the address by one stride
   assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (rd_addr_o == $past(rd_addr_o) + STEP));

   // R9: once finished, the sequencer stays finished
   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && !rd_req_o));

endmodule

// File: rtl/nvcfg_pack.sv
module nvcfg_pack import nvcfg_pkg::*; #(
   parameter int BYTE_W    = 8,
   parameter int NUM_PAIRS = 8,
   parameter int REG_W     = 32
) (
   input  logic [NUM_PAIRS*BYTE_W-1:0] bytes_i,
   input  logic                        err_i,
   output logic [REG_W-1:0]            ucfg_o,
   output logic [REG_W-1:0]            wprot_o,
   output prot_lvl_e                   lvl_o
);

   localparam int NUM_WP = NUM_PAIRS - PR_WP0;
   localparam int WP_W   = NUM_WP * BYTE_W;

   logic [BYTE_W-1:0] acc;
   logic              open_key;
   logic              high_key;

   assign acc      = bytes_i[PR_ACC*BYTE_W +: BYTE_W];
   assign open_key = (acc == BYTE_W'(KEY_OPEN));
   assign high_key = (acc == BYTE_W'(KEY_HIGH));

   always_comb begin
      ucfg_o                         = '0;
      ucfg_o[FLD_ERR]                = err_i;
      ucfg_o[FLD_PROT_EN]            = !open_key;
      ucfg_o[FLD_SYS  +: BYTE_W]     = bytes_i[PR_SYS*BYTE_W  +: BYTE_W];
      ucfg_o[FLD_USR0 +: BYTE_W]     = bytes_i[PR_USR0*BYTE_W +: BYTE_W];
      ucfg_o[FLD_USR1 +: BYTE_W]     = bytes_i[PR_USR1*BYTE_W +: BYTE_W];
      ucfg_o[FLD_PROT_HI]            = high_key;
   end

   always_comb begin
      if (open_key) begin
         lvl_o = LVL_NONE;
      end else if (high_key) begin
         lvl_o = LVL_HIGH;
      end else begin
         lvl_o = LVL_LOW;
      end
   end

   generate
      for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
         assign wprot_o[k*BYTE_W +: BYTE_W] = bytes_i[(PR_WP0 + k)*BYTE_W +: BYTE_W];
      end
      if (WP_W < REG_W) begin : g_wp_pad
         assign wprot_o[REG_W-1:WP_W] = '0;
      end
   endgenerate

endmodule

// File: rtl/nvcfg_loader.sv
module nvcfg_loader import nvcfg_pkg::*; #(
   parameter int ADDR_W       = 12,
   parameter int BASE_ADDR    = 'h800,
   parameter int STRIDE       = 4,
   parameter int NUM_WORDS    = 4,
   parameter int BYTE_W       = 8,
   parameter bit ACCEPT_BLANK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                rd_req_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic                rd_valid_i,
   input  logic [4*BYTE_W-1:0] rd_data_i,
   output logic                load_done_o,
   output logic                cfg_err_o,
   output logic [4*BYTE_W-1:0] ucfg_o,
   output logic [4*BYTE_W-1:0] wprot_o,
   output logic [1:0]          prot_lvl_o
);

   localparam int WORD_W    = 4 * BYTE_W;
   localparam int PAIR_W    = 2 * BYTE_W;
   localparam int PAIRS_PW  = WORD_W / PAIR_W;
   localparam int NUM_PAIRS = NUM_WORDS * PAIRS_PW;
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   generate
      if (NUM_WORDS != 4) begin : g_bad_words
         $error("nvcfg_loader: register layout needs exactly four words");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("nvcfg_loader: register layout needs 8-bit entries");
      end
      if (STRIDE < 1) begin : g_bad_stride
         $error("nvcfg_loader: STRIDE must be positive");
      end
      if (BASE_ADDR + STRIDE*(NUM_WORDS-1) >= (1 << ADDR_W)) begin : g_bad_addr
         $error("nvcfg_loader: word window exceeds ADDR_W");
      end
   endgenerate

   logic             take;
   logic [IDX_W-1:0] idx;
   logic             pack;
   logic             seq_done;

   nvcfg_read_seq #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .STRIDE    (STRIDE),
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req_o   (rd_req_o),
      .rd_addr_o  (rd_addr_o),
      .rd_valid_i (rd_valid_i),
      .take_o     (take),
      .idx_o      (idx),
      .pack_o     (pack),
      .done_o     (seq_done)
   );

   // screen both entries of the word on the bus
   logic [BYTE_W-1:0] chk_val [PAIRS_PW];
   logic [PAIRS_PW-1:0] chk_bad;

   generate
      for (genvar g = 0; g < PAIRS_PW; g++) begin : g_pc
         nvcfg_pair_check #(
            .BYTE_W       (BYTE_W),
            .ACCEPT_BLANK (ACCEPT_BLANK)
         ) u_pc (
            .pair_i  (rd_data_i[g*PAIR_W +: PAIR_W]),
            .value_o (chk_val[g]),
            .bad_o   (chk_bad[g])
         );
      end
   endgenerate

   // screened byte store and sticky error
   logic [BYTE_W-1:0] clean_q [NUM_PAIRS];
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PAIRS; p++) begin
            clean_q[p] <= '1;
         end
         err_q <= 1'b0;
      end else if (take) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
               for (int g = 0; g < PAIRS_PW; g++) begin
                  clean_q[w*PAIRS_PW + g] <= chk_val[g];
               end
            end
         end
         err_q <= err_q | (|chk_bad);
      end
   end

   logic [NUM_PAIRS*BYTE_W-1:0] bytes_flat;

   generate
      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_flat
         assign bytes_flat[p*BYTE_W +: BYTE_W] = clean_q[p];
      end
   endgenerate

   logic [WORD_W-1:0] pk_ucfg;
   logic [WORD_W-1:0] pk_wprot;
   prot_lvl_e         pk_lvl;

   nvcfg_pack #(
      .BYTE_W    (BYTE_W),
      .NUM_PAIRS (NUM_PAIRS),
      .REG_W     (WORD_W)
   ) u_pack (
      .bytes_i (bytes_flat),
      .err_i   (err_q),
      .ucfg_o  (pk_ucfg),
      .wprot_o (pk_wprot),
      .lvl_o   (pk_lvl)
   );

   // output registers: all ones until the pack cycle writes them
   logic [WORD_W-1:0] ucfg_q;
   logic [WORD_W-1:0] wprot_q;
   prot_lvl_e         lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ucfg_q  <= '1;
         wprot_q <= '1;
         lvl_q   <= LVL_PEND;
      end else if (pack) begin
         ucfg_q  <= pk_ucfg;
         wprot_q <= pk_wprot;
         lvl_q   <= pk_lvl;
      end
   end

   assign ucfg_o      = ucfg_q;
   assign wprot_o     = wprot_q;
   assign prot_lvl_o  = lvl_q;
   assign cfg_err_o   = err_q;
   assign load_done_o = seq_done;

   // R2: registers read all ones until the load finishes
   assert_busy_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done_o |-> ((ucfg_o == '1) && (wprot_o == '1) && (prot_lvl_o == LVL_PEND)));

   // R5: error flag never clears without reset
   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> cfg_err_o);

   // R5: register bit 0 reports the flag after the load
   assert_err_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_done_o |-> (ucfg_o[FLD_ERR] == cfg_err_o));

   // R6: top bits of the user register are zero after the load
   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_done_o |-> (ucfg_o[WORD_W-1:FLD_PROT_HI+1] == '0));

   // R8: level output agrees with the two protection bits
   assert_lvl_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_done_o |-> ((ucfg_o[FLD_PROT_HI] == (prot_lvl_o == LVL_HIGH)) &&
                       (ucfg_o[FLD_PROT_EN] == (prot_lvl_o != LVL_NONE))));

   // R9: outputs frozen once done
   assert_regs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done_o |=> ($stable(ucfg_o) && $stable(wprot_o) && $stable(prot_lvl_o)));

endmodule

// File: tb/tb_nvcfg_loader.sv
module tb_nvcfg_loader;

   localparam int AW = 12;
   localparam int BASE = 'h800;

   logic        clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic          done;
   logic          err;
   logic [31:0]   ucfg;
   logic [31:0]   wprot;
   logic [1:0]    lvl;

   nvcfg_loader dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_req_o    (rd_req),
      .rd_addr_o   (rd_addr),
      .rd_valid_i  (rd_valid),
      .rd_data_i   (rd_data),
      .load_done_o (done),
      .cfg_err_o   (err),
      .ucfg_o      (ucfg),
      .wprot_o     (wprot),
      .prot_lvl_o  (lvl)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [31:0]   mem [4];
   int            lat = 0;
   int            nacc = 0;
   int            wait_cnt = 0;
   logic [AW-1:0] alog [8];
   bit            prev_err = 1'b0;

   // read responder: answers after lat idle cycles, garbage otherwise
   initial begin
      rd_valid = 1'b0;
      rd_data  = 32'h0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            rd_valid = 1'b0;
            rd_data  = 32'h5A5A_C3C3;
            wait_cnt = 0;
            nacc     = 0;
         end else if (rd_req) begin
            if (wait_cnt >= lat) begin
               int w;
               w = (int'(rd_addr) - BASE) / 4;
               rd_valid = 1'b1;
               rd_data  = (w >= 0 && w < 4) ? mem[w] : 32'h0;
               if (nacc < 8) alog[nacc] = rd_addr;
               nacc++;
               wait_cnt = 0;
            end else begin
               rd_valid = 1'b0;
               rd_data  = 32'h1234_0000 ^ {16'h0, rd_addr, 4'h0} ^ 32'(wait_cnt);
               wait_cnt++;
            end
         end else begin
            rd_valid = 1'b0;
            rd_data  = 32'hA5A5_0F0F;
            wait_cnt = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [7:0] b);
      return {~b, b};
   endfunction

   // returns {bad, value}
   function automatic logic [8:0] screen(input logic [15:0] p);
      logic [7:0] lo, hi;
      lo = p[7:0];
      hi = p[15:8];
      if (hi == ~lo) return {1'b0, lo};
      if (lo == 8'hFF && hi == 8'hFF) return {1'b0, 8'hFF};
      return {1'b1, 8'hFF};
   endfunction

   task automatic run_load(input logic [15:0] pr [8], input int l, input int kind_tag);
      logic [7:0]  v [8];
      logic        e;
      logic [31:0] exp_u, exp_w;
      logic [1:0]  exp_l;
      logic [31:0] u_hold;
      int n;
      for (int w = 0; w < 4; w++) mem[w] = {pr[2*w+1], pr[2*w]};
      lat   = l;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(ucfg == 32'hFFFF_FFFF && wprot == 32'hFFFF_FFFF && !done, "R2 reset regs", ucfg, 32'hFFFF_FFFF);
      chk(!err, "R10 err cleared by reset", {31'h0, err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ucfg == 32'hFFFF_FFFF && wprot == 32'hFFFF_FFFF && lvl == 2'b11 && !done,
          "R2 busy regs", wprot, 32'hFFFF_FFFF);
      n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      e = 1'b0;
      for (int k = 0; k < 8; k++) begin
         logic [8:0] s;
         s = screen(pr[k]);
         v[k] = s[7:0];
         e = e | s[8];
      end
      exp_u = {5'b0, v[0] == 8'hCC, v[3], v[2], v[1], v[0] != 8'hA5, e};
      exp_w = {v[7], v[6], v[5], v[4]};
      exp_l = (v[0] == 8'hA5) ? 2'b00 : (v[0] == 8'hCC) ? 2'b10 : 2'b01;
      chk(done, "R9 done reached", {31'h0, done}, 32'h1);
      chk(nacc == 4, "R1 word count", 32'(nacc), 32'd4);
      for (int k = 0; k < 4; k++)
         chk(alog[k] == AW'(BASE + 4*k), "R1 address order", 32'(alog[k]), 32'(BASE + 4*k));
      chk(ucfg[25:2] == exp_u[25:2], "R6 packed fields", ucfg, exp_u);
      chk(ucfg[31:27] == 5'b0, "R6 upper zero", ucfg, exp_u);
      chk(ucfg[26] == exp_u[26] && ucfg[1] == exp_u[1], "R8 protection bits", ucfg, exp_u);
      chk(lvl == exp_l, "R8 level", 32'(lvl), 32'(exp_l));
      chk(wprot == exp_w, "R7 protection status", wprot, exp_w);
      if (e) chk(err == 1'b1 && ucfg[0], "R5 error raised", {31'h0, err}, 32'h1);
      else   chk(err == 1'b0 && !ucfg[0], "R3 no error", {31'h0, err}, 32'h0);
      if (kind_tag == 2) chk(!e ? (err == 1'b0) : 1'b1, "R4 blank accepted", {31'h0, err}, 32'h0);
      if (prev_err && !e) chk(err == 1'b0, "R10 reload clears error", {31'h0, err}, 32'h0);
      if (l > 0) chk(ucfg == exp_u, "R11 idle data ignored", ucfg, exp_u);
      prev_err = e;
      u_hold = ucfg;
      repeat (3) @(negedge clk);
      chk(!rd_req && done && ucfg == u_hold && nacc == 4, "R9 quiet after done", {31'h0, rd_req}, 32'h0);
      chk(!e || err, "R5 error sticky", {31'h0, err}, 32'h1);
   endtask

   initial begin
      logic [15:0] pr [8];
      rst_n = 1'b0;
      for (int w = 0; w < 4; w++) mem[w] = 32'h0;
      repeat (2) @(negedge clk);

      // sweep the access byte with correct complements everywhere
      for (int a = 0; a < 256; a++) begin
         logic [7:0] b;
         b = 8'(a);
         pr[0] = mk(b);
         pr[1] = mk(b ^ 8'h5A);
         pr[2] = mk(b + 8'd7);
         pr[3] = mk(~b);
         pr[4] = mk(8'(b * 3));
         pr[5] = mk(b ^ 8'h0F);
         pr[6] = mk(8'hFF - b);
         pr[7] = mk({b[6:0], b[7]});
         run_load(pr, a % 3, 0);
      end

      // sweep one entry against four kinds of high byte, rotating its slot
      for (int lo = 0; lo < 256; lo++) begin
         for (int kind = 0; kind < 4; kind++) begin
            logic [7:0] l8, h8;
            int pos;
            l8 = 8'(lo);
            case (kind)
               0: h8 = ~l8;
               1: h8 = ~l8 ^ (8'h1 << (lo % 8));
               2: h8 = 8'hFF;
               default: h8 = l8;
            endcase
            for (int k = 0; k < 8; k++) pr[k] = mk(8'(8'h10 + 8'(k * 17)));
            pos = (lo + kind) % 8;
            if (kind == 2) l8 = (lo % 2 == 0) ? 8'hFF : l8;
            pr[pos] = {h8, l8};
            run_load(pr, kind % 2, (kind == 2 && l8 == 8'hFF) ? 2 : 0);
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog expired act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule